// File: doc/BRIEF.md
# Architectural State Resync Controller

This controller rebuilds the state of a run-ahead (leading) core from the precise state held by the trailing core that re-executes its retired stream. Two events start a resync: a branch misprediction found by the trailing core while the pair runs as one thread, and a change between single-thread and multithread operation. A resync squashes both pipelines, empties the inter-core queue, hands the source core's program counter to the destination, resets the destination's rename map and streams the architectural registers across a fixed number of lanes per cycle. Memory state is never copied, since only the trailing core writes the data caches; the leader's speculative store cache is simply invalidated.

The mode is chosen by a miss counter. Over each window of retired instructions it counts L2 misses; a high count asks for single-thread operation (leader runs ahead with miss invalidation, trailer fetches from the queue), a low count asks for multithread operation, and a count between two programmable thresholds keeps the current choice. A pending mode change starts its own resync: single-to-multithread copies trailer to leader, multithread-to-single copies leader to trailer. A one-cycle done pulse releases both fetch stages.

Top module: `arch_resync_ctrl`

## Requirements
- R1: After reset the controller is idle: fetch_hold_o, squash_o, q_flush_o, pc_wr_o, rename_reset_o, st_cache_inv_o, rd_en_o, wr_en_o and done_o are 0, and single_mode_o is 1 (single-thread).
- R2: A mispredict_i seen while idle in single-thread mode gives, in the next cycle, a one-cycle pulse on squash_o, q_flush_o, rename_reset_o, st_cache_inv_o and pc_wr_o, with pc_o equal to trail_pc_i from the trigger cycle and copy_dir_o = 0 (0 = trailer to leader, 1 = leader to trailer).
- R3: In the 16 cycles after the squash pulse the controller reads register groups 0 to 15 in ascending order, one per cycle (rd_en_o, rd_grp_o); each group is presented on the write port (wr_en_o, wr_grp_o, wr_data_o) one cycle after its read, with lane l of group g, bits [32*l+31:32*l], holding register 4*g+l.
- R4: done_o pulses for one cycle 17 cycles after the squash pulse, together with the last write; fetch_hold_o is 1 from the squash cycle through the done cycle and 0 afterwards.
- R5: A trigger that arrives while a resync is in progress, including in the done cycle, is ignored: no second squash pulse and no further resync.
- R6: In multithread mode (single_mode_o = 0) mispredict_i has no effect.
- R7: After each window of WINDOW retire_i pulses the miss count of that window (misses flagged with a retire or in between) is compared: count >= thr_hi_i requests single-thread, count < thr_lo_i requests multithread, anything in between keeps the previous request.
- R8: A request for multithread while in single-thread mode starts a resync with copy_dir_o = 0, pc_o = trail_pc_i and st_cache_inv_o pulsed; single_mode_o falls in the cycle after done_o.
- R9: A request for single-thread while in multithread mode starts a resync with copy_dir_o = 1, pc_o = lead_pc_i, rename_reset_o pulsed and st_cache_inv_o not pulsed; the registers come from the leader file, and single_mode_o rises in the cycle after done_o.
- R10: A mode change and a misprediction seen in the same idle cycle give exactly one resync, the mode-change one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mispredict_i | input | 1 | Branch misprediction detected at the trailing core |
| retire_i | input | 1 | One instruction retired at the trailing core |
| l2_miss_i | input | 1 | One L2 miss observed |
| thr_hi_i | input | CNT_W | Miss count at or above which single-thread is requested |
| thr_lo_i | input | CNT_W | Miss count below which multithread is requested |
| trail_pc_i | input | PC_W | Trailing core's architectural program counter |
| lead_pc_i | input | PC_W | Leading core's architectural program counter |
| rd_data_i | input | LANES*DATA_W | Register group read from the source file selected by copy_dir_o |
| squash_o | output | 1 | Squash both pipelines |
| q_flush_o | output | 1 | Empty the inter-core queue |
| fetch_hold_o | output | 1 | Hold both fetch stages |
| pc_wr_o | output | 1 | Load pc_o into the destination core |
| pc_o | output | PC_W | Program counter handed to the destination |
| rename_reset_o | output | 1 | Reset the destination core's rename map |
| st_cache_inv_o | output | 1 | Invalidate the leader's speculative store cache |
| copy_dir_o | output | 1 | 0 = trailer to leader, 1 = leader to trailer |
| rd_en_o | output | 1 | Source register group read |
| rd_grp_o | output | GRP_W | Source register group index |
| wr_en_o | output | 1 | Destination register group write |
| wr_grp_o | output | GRP_W | Destination register group index |
| wr_data_o | output | LANES*DATA_W | Destination register group data |
| done_o | output | 1 | Resync finished; releases fetch |
| single_mode_o | output | 1 | 1 = single-thread (invalidation on, trailer fetches from queue) |

## Verification
The misprediction trigger and the window evaluation of the miss counter can land in the same idle cycle. The bench drives the last retire of a low-miss window while single-threaded, then raises mispredict_i exactly in the cycle the new mode request becomes visible, and judges the result by a single squash pulse, trailer-to-leader data, a falling single_mode_o after done and several quiet cycles with no second resync. The same mechanism is also probed with triggers injected mid-copy and in the done cycle.

// File: rtl/resync_pkg.sv
package resync_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FLUSH = 2'd1,
        ST_COPY  = 2'd2,
        ST_DONE  = 2'd3
    } rs_state_e;

    typedef enum logic {
        DIR_T2L = 1'b0,
        DIR_L2T = 1'b1
    } rs_dir_e;

endpackage

// File: rtl/rs_mode_sel.sv
module rs_mode_sel #(
    parameter int WINDOW = 256,
    parameter int CNT_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             retire_i,
    input  logic             l2_miss_i,
    input  logic [CNT_W-1:0] thr_hi_i,
    input  logic [CNT_W-1:0] thr_lo_i,
    output logic             want_single_o
);

    localparam int WIN_W = (WINDOW > 2) ? $clog2(WINDOW) : 1;

    typedef struct packed {
        logic [WIN_W-1:0] win_cnt;
        logic [CNT_W-1:0] miss_cnt;
        logic             want_single;
    } sel_t;

    sel_t q, d;
    logic [CNT_W-1:0] miss_sum;
    logic             win_end;

    always_comb begin
        d        = q;
        miss_sum = q.miss_cnt;
        if (l2_miss_i && (q.miss_cnt != {CNT_W{1'b1}})) begin
            miss_sum = q.miss_cnt + CNT_W'(1);
        end
        win_end = retire_i && (q.win_cnt == WIN_W'(WINDOW - 1));
        d.miss_cnt = miss_sum;
        if (retire_i) begin
            d.win_cnt = q.win_cnt + WIN_W'(1);
        end
        if (win_end) begin
            d.win_cnt  = '0;
            d.miss_cnt = '0;
            if (miss_sum >= thr_hi_i) begin
                d.want_single = 1'b1;
            end else if (miss_sum < thr_lo_i) begin
                d.want_single = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{win_cnt: '0, miss_cnt: '0, want_single: 1'b1};
        end else begin
            q <= d;
        end
    end

    assign want_single_o = q.want_single;

endmodule

// File: rtl/rs_copy_pipe.sv
module rs_copy_pipe #(
    parameter int LANES  = 4,
    parameter int DATA_W = 32,
    parameter int GRP_W  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    rd_en_i,
    input  logic [GRP_W-1:0]        rd_grp_i,
    input  logic [LANES*DATA_W-1:0] rd_data_i,
    output logic                    wr_en_o,
    output logic [GRP_W-1:0]        wr_grp_o,
    output logic [LANES*DATA_W-1:0] wr_data_o
);

    typedef struct packed {
        logic             en;
        logic [GRP_W-1:0] grp;
    } ctl_t;

    ctl_t ctl_q, ctl_d;

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.en  = rd_en_i;
        if (rd_en_i) begin
            ctl_d.grp = rd_grp_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [DATA_W-1:0] lane_d, lane_q;

        always_comb begin
            lane_d = lane_q;
            if (rd_en_i) begin
                lane_d = rd_data_i[l*DATA_W +: DATA_W];
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lane_q <= '0;
            end else begin
                lane_q <= lane_d;
            end
        end

        assign wr_data_o[l*DATA_W +: DATA_W] = lane_q;
    end

    assign wr_en_o  = ctl_q.en;
    assign wr_grp_o = ctl_q.grp;

endmodule

// File: rtl/arch_resync_ctrl.sv
module arch_resync_ctrl #(
    parameter int NUM_REGS = 64,
    parameter int LANES    = 4,
    parameter int DATA_W   = 32,
    parameter int PC_W     = 32,
    parameter int WINDOW   = 256,
    parameter int CNT_W    = 8,
    localparam int NUM_GROUPS = NUM_REGS / LANES,
    localparam int GRP_W      = (NUM_GROUPS > 2) ? $clog2(NUM_GROUPS) : 1,
    localparam int BUS_W      = LANES * DATA_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mispredict_i,
    input  logic             retire_i,
    input  logic             l2_miss_i,
    input  logic [CNT_W-1:0] thr_hi_i,
    input  logic [CNT_W-1:0] thr_lo_i,
    input  logic [PC_W-1:0]  trail_pc_i,
    input  logic [PC_W-1:0]  lead_pc_i,
    input  logic [BUS_W-1:0] rd_data_i,
    output logic             squash_o,
    output logic             q_flush_o,
    output logic             fetch_hold_o,
    output logic             pc_wr_o,
    output logic [PC_W-1:0]  pc_o,
    output logic             rename_reset_o,
    output logic             st_cache_inv_o,
    output logic             copy_dir_o,
    output logic             rd_en_o,
    output logic [GRP_W-1:0] rd_grp_o,
    output logic             wr_en_o,
    output logic [GRP_W-1:0] wr_grp_o,
    output logic [BUS_W-1:0] wr_data_o,
    output logic             done_o,
    output logic             single_mode_o
);

    import resync_pkg::*;

    typedef struct packed {
        rs_state_e        state;
        logic [GRP_W-1:0] grp;
        rs_dir_e          dir;
        logic [PC_W-1:0]  pc;
        logic             single;
        logic             flip;
    } ctrl_t;

    ctrl_t q, d;
    logic  want_single;
    logic  mode_chg;

    rs_mode_sel #(
        .WINDOW (WINDOW),
        .CNT_W  (CNT_W)
    ) i_mode_sel (
        .clk           (clk),
        .rst_n         (rst_n),
        .retire_i      (retire_i),
        .l2_miss_i     (l2_miss_i),
        .thr_hi_i      (thr_hi_i),
        .thr_lo_i      (thr_lo_i),
        .want_single_o (want_single)
    );

    always_comb begin
        d        = q;
        mode_chg = (want_single != q.single);
        unique case (q.state)
            ST_IDLE: begin
                d.grp = '0;
                if (mode_chg) begin
                    // mode change wins and also covers a same-cycle mispredict
                    d.state = ST_FLUSH;
                    d.flip  = 1'b1;
                    d.dir   = q.single ? DIR_T2L : DIR_L2T;
                    d.pc    = q.single ? trail_pc_i : lead_pc_i;
                end else if (mispredict_i && q.single) begin
                    d.state = ST_FLUSH;
                    d.flip  = 1'b0;
                    d.dir   = DIR_T2L;
                    d.pc    = trail_pc_i;
                end
            end
            ST_FLUSH: begin
                d.state = ST_COPY;
                d.grp   = '0;
            end
            ST_COPY: begin
                if (q.grp == GRP_W'(NUM_GROUPS - 1)) begin
                    d.state = ST_DONE;
                end else begin
                    d.grp = q.grp + GRP_W'(1);
                end
            end
            ST_DONE: begin
                d.state = ST_IDLE;
                if (q.flip) begin
                    d.single = ~q.single;
                end
                d.flip = 1'b0;
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{state: ST_IDLE, grp: '0, dir: DIR_T2L, pc: '0,
                   single: 1'b1, flip: 1'b0};
        end else begin
            q <= d;
        end
    end

    rs_copy_pipe #(
        .LANES  (LANES),
        .DATA_W (DATA_W),
        .GRP_W  (GRP_W)
    ) i_copy_pipe (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en_i   (rd_en_o),
        .rd_grp_i  (rd_grp_o),
        .rd_data_i (rd_data_i),
        .wr_en_o   (wr_en_o),
        .wr_grp_o  (wr_grp_o),
        .wr_data_o (wr_data_o)
    );

    assign squash_o       = (q.state == ST_FLUSH);
    assign q_flush_o      = (q.state == ST_FLUSH);
    assign pc_wr_o        = (q.state == ST_FLUSH);
    assign rename_reset_o = (q.state == ST_FLUSH);
    assign st_cache_inv_o = (q.state == ST_FLUSH) && (q.dir == DIR_T2L);
    assign pc_o           = q.pc;
    assign copy_dir_o     = q.dir;
    assign fetch_hold_o   = (q.state != ST_IDLE);
    assign rd_en_o        = (q.state == ST_COPY);
    assign rd_grp_o       = q.grp;
    assign done_o         = (q.state == ST_DONE);
    assign single_mode_o  = q.single;

endmodule

// File: rtl/rs_checker.sv
module rs_checker #(
    parameter int NUM_GROUPS = 16,
    parameter int GRP_W      = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             squash_o,
    input logic             q_flush_o,
    input logic             fetch_hold_o,
    input logic             st_cache_inv_o,
    input logic             copy_dir_o,
    input logic             rd_en_o,
    input logic [GRP_W-1:0] rd_grp_o,
    input logic             wr_en_o,
    input logic [GRP_W-1:0] wr_grp_o,
    input logic             done_o,
    input logic             single_mode_o
);

    logic [15:0] since_sq;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_sq <= '0;
        end else if (squash_o) begin
            since_sq <= 16'd1;
        end else if (since_sq != '0 && since_sq != 16'hFFFF) begin
            since_sq <= since_sq + 16'd1;
        end
    end

    a_r2_flush_with_squash: assert property (@(posedge clk) disable iff (!rst_n)
        squash_o |-> q_flush_o && fetch_hold_o);

    a_r3_write_tracks_read: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> $past(rd_en_o) && (wr_grp_o == $past(rd_grp_o)));

    a_r3_ascending_groups: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_o && $past(rd_en_o)) |-> (rd_grp_o == GRP_W'($past(rd_grp_o) + 1'b1)));

    a_r4_done_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (since_sq == 16'(NUM_GROUPS + 1)));

    a_r4_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o && !fetch_hold_o);

    a_r5_no_squash_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        squash_o |-> !$past(fetch_hold_o));

    a_r8_mode_flips_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        (single_mode_o != $past(single_mode_o)) |-> $past(done_o));

    a_r9_inv_only_toward_leader: assert property (@(posedge clk) disable iff (!rst_n)
        st_cache_inv_o |-> (copy_dir_o == 1'b0));

endmodule

bind arch_resync_ctrl rs_checker #(
    .NUM_GROUPS (NUM_GROUPS),
    .GRP_W      (GRP_W)
) i_rs_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .squash_o       (squash_o),
    .q_flush_o      (q_flush_o),
    .fetch_hold_o   (fetch_hold_o),
    .st_cache_inv_o (st_cache_inv_o),
    .copy_dir_o     (copy_dir_o),
    .rd_en_o        (rd_en_o),
    .rd_grp_o       (rd_grp_o),
    .wr_en_o        (wr_en_o),
    .wr_grp_o       (wr_grp_o),
    .done_o         (done_o),
    .single_mode_o  (single_mode_o)
);

// File: tb/test_arch_resync_ctrl.sv
module test_arch_resync_ctrl;

    localparam int NREG  = 64;
    localparam int LN    = 4;
    localparam int DW    = 32;
    localparam int NGRP  = NREG / LN;
    localparam int GW    = 4;
    localparam int WIN   = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            mispredict = 1'b0;
    logic            retire = 1'b0;
    logic            l2_miss = 1'b0;
    logic [7:0]      thr_hi = 8'd8;
    logic [7:0]      thr_lo = 8'd3;
    logic [31:0]     trail_pc = 32'h0000_4000;
    logic [31:0]     lead_pc  = 32'h0000_9000;
    logic [LN*DW-1:0] rd_data;
    logic squash, qflush, hold, pc_wr, ren_rst, st_inv, cdir, rd_en, wr_en, done, single;
    logic [31:0] pc;
    logic [GW-1:0] rd_grp, wr_grp;
    logic [LN*DW-1:0] wr_data;

    int checks = 0;
    int fails  = 0;
    int epoch  = 0;

    logic [31:0] got [NREG];
    bit          got_v [NREG];
    int          next_grp;
    int          order_bad;

    always #4 clk = ~clk;

    arch_resync_ctrl #(
        .NUM_REGS (NREG), .LANES (LN), .DATA_W (DW), .PC_W (32),
        .WINDOW (WIN), .CNT_W (8)
    ) i_arch_resync_ctrl (
        .clk (clk), .rst_n (rst_n), .mispredict_i (mispredict),
        .retire_i (retire), .l2_miss_i (l2_miss),
        .thr_hi_i (thr_hi), .thr_lo_i (thr_lo),
        .trail_pc_i (trail_pc), .lead_pc_i (lead_pc), .rd_data_i (rd_data),
        .squash_o (squash), .q_flush_o (qflush), .fetch_hold_o (hold),
        .pc_wr_o (pc_wr), .pc_o (pc), .rename_reset_o (ren_rst),
        .st_cache_inv_o (st_inv), .copy_dir_o (cdir), .rd_en_o (rd_en),
        .rd_grp_o (rd_grp), .wr_en_o (wr_en), .wr_grp_o (wr_grp),
        .wr_data_o (wr_data), .done_o (done), .single_mode_o (single)
    );

    function automatic logic [31:0] src_val(input logic dir, input int idx);
        return {(dir ? 8'hB7 : 8'h4C), 8'(epoch), 8'h00, 8'(idx)};
    endfunction

    // source register file model, selected by copy direction
    always_comb begin
        for (int l = 0; l < LN; l++) begin
            rd_data[l*DW +: DW] = src_val(cdir, int'(rd_grp) * LN + l);
        end
    end

    always @(negedge clk) begin
        if (wr_en) begin
            if (int'(wr_grp) != next_grp) order_bad++;
            next_grp = int'(wr_grp) + 1;
            for (int l = 0; l < LN; l++) begin
                got[int'(wr_grp) * LN + l]   = wr_data[l*DW +: DW];
                got_v[int'(wr_grp) * LN + l] = 1'b1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic idle_cycles(input string req, input int n, input logic exp_mode);
        int busy = 0;
        int sq = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (hold) busy++;
            if (squash) sq++;
        end
        chk(busy == 0, req, "fetch_hold while idle", 64'(busy), 0);
        chk(sq == 0, req, "unexpected squash", 64'(sq), 0);
        chk(single == exp_mode, req, "mode held", 64'(single), 64'(exp_mode));
    endtask

    // called at the negedge where the trigger is visible to the next edge
    task automatic resync_check(input string req, input logic exp_dir,
                                input logic [31:0] exp_pc, input logic exp_inv,
                                input logic exp_mode, input int inject);
        int done_at = 0;
        int extra_sq = 0;
        int drops = 0;
        int bad = 0;
        @(negedge clk);
        mispredict = 1'b0;
        retire     = 1'b0;
        l2_miss    = 1'b0;
        chk(squash == 1'b1, req, "squash pulse", 64'(squash), 1);
        chk(qflush == 1'b1, req, "queue flush", 64'(qflush), 1);
        chk(ren_rst == 1'b1, req, "rename reset", 64'(ren_rst), 1);
        chk(pc_wr == 1'b1 && pc == exp_pc, req, "pc handoff", 64'(pc), 64'(exp_pc));
        chk(st_inv == exp_inv, req, "store cache invalidate", 64'(st_inv), 64'(exp_inv));
        chk(cdir == exp_dir, req, "copy direction", 64'(cdir), 64'(exp_dir));
        chk(hold == 1'b1, req, "fetch hold", 64'(hold), 1);
        for (int r = 0; r < NREG; r++) got_v[r] = 1'b0;
        next_grp  = 0;
        order_bad = 0;
        for (int i = 1; i <= 20 && done_at == 0; i++) begin
            if (inject == 1 && i == 6) mispredict = 1'b1;
            @(negedge clk);
            mispredict = 1'b0;
            if (squash) extra_sq++;
            if (!hold) drops++;
            if (done) done_at = i;
        end
        chk(done_at == NGRP + 1, "R4", "done cycle after squash", 64'(done_at), 64'(NGRP + 1));
        chk(drops == 0, "R4", "fetch hold gaps", 64'(drops), 0);
        chk(extra_sq == 0, "R5", "second squash during copy", 64'(extra_sq), 0);
        if (inject == 2) mispredict = 1'b1;
        @(negedge clk);
        mispredict = 1'b0;
        chk(hold == 1'b0 && done == 1'b0, "R4", "released after done", 64'({hold, done}), 0);
        chk(single == exp_mode, req, "mode after done", 64'(single), 64'(exp_mode));
        for (int r = 0; r < NREG; r++) begin
            if (!got_v[r] || got[r] != src_val(exp_dir, r)) bad++;
        end
        chk(bad == 0, "R3", "registers copied", 64'(bad), 0);
        chk(order_bad == 0, "R3", "write order", 64'(order_bad), 0);
    endtask

    // drives one full window; returns at the negedge after the evaluating edge
    task automatic run_window(input int misses);
        for (int i = 0; i < WIN; i++) begin
            retire  = 1'b1;
            l2_miss = (i < misses);
            @(negedge clk);
        end
        retire  = 1'b0;
        l2_miss = 1'b0;
    endtask

    task automatic t_reset;
        chk(!hold && !squash && !qflush && !pc_wr && !ren_rst && !st_inv,
            "R1", "control outputs idle", 64'({hold, squash, qflush, pc_wr, ren_rst, st_inv}), 0);
        chk(!rd_en && !wr_en && !done, "R1", "copy idle", 64'({rd_en, wr_en, done}), 0);
        chk(single == 1'b1, "R1", "reset mode", 64'(single), 1);
    endtask

    task automatic t_mispredict_single;
        epoch++;
        trail_pc = 32'h0000_4A10;
        mispredict = 1'b1;
        resync_check("R2", 1'b0, 32'h0000_4A10, 1'b1, 1'b1, 0);
    endtask

    task automatic t_retrigger_mid;
        epoch++;
        trail_pc = 32'h0000_5000;
        mispredict = 1'b1;
        resync_check("R5", 1'b0, 32'h0000_5000, 1'b1, 1'b1, 1);
        idle_cycles("R5", 4, 1'b1);
    endtask

    task automatic t_retrigger_done;
        epoch++;
        trail_pc = 32'h0000_5100;
        mispredict = 1'b1;
        resync_check("R5", 1'b0, 32'h0000_5100, 1'b1, 1'b1, 2);
        idle_cycles("R5", 4, 1'b1);
    endtask

    task automatic t_to_multi;
        epoch++;
        trail_pc = 32'h0000_6200;
        run_window(1);
        resync_check("R8", 1'b0, 32'h0000_6200, 1'b1, 1'b0, 0);
    endtask

    task automatic t_mispredict_multi;
        mispredict = 1'b1;
        @(negedge clk);
        mispredict = 1'b0;
        idle_cycles("R6", 5, 1'b0);
    endtask

    task automatic t_hold_multi;
        run_window(7);
        idle_cycles("R7", 5, 1'b0);
    endtask

    task automatic t_to_single;
        epoch++;
        lead_pc = 32'h0000_9A40;
        run_window(8);
        resync_check("R9", 1'b1, 32'h0000_9A40, 1'b0, 1'b1, 0);
    endtask

    task automatic t_hold_single;
        run_window(3);
        idle_cycles("R7", 5, 1'b1);
    endtask

    task automatic t_same_cycle;
        epoch++;
        trail_pc = 32'h0000_7700;
        run_window(0);
        mispredict = 1'b1;
        resync_check("R10", 1'b0, 32'h0000_7700, 1'b1, 1'b0, 0);
        idle_cycles("R10", 5, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mispredict_single();
        t_retrigger_mid();
        t_retrigger_done();
        t_to_multi();
        t_mispredict_multi();
        t_hold_multi();
        t_to_single();
        t_hold_single();
        t_same_cycle();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule